// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block guards a processor with a watchdog that runs in two consecutive timeout phases, timed in prescaled bus-clock ticks. While the first phase runs, software keeps the system alive by writing the ping word, which restarts the phase. If the first phase runs out, the block raises a pre-timeout interrupt and moves straight into the second phase. That phase only buys the system time to clean up or warn other agents. When it runs out, the block raises a timeout interrupt and, in the same cycle, a one-cycle reset request tagged with a reset scope.

Software reaches the block through three 32-bit words: a control word (enable, interrupt enables, reset scope, phase lengths), a ping word and a sticky interrupt status word. The prescaler divide is a parameter. Its default of 2^28 bus cycles per tick gives about 43 s for 32 ticks at 200 MHz, and a bench can set a small value.

Top module: `twophase_wdog`

## Requirements
- R1: After reset the timer is disabled, `irq_pre`, `irq_tmo` and `reset_req` are low, `reset_mode` is 01, the status word reads 0, and the control word reads with both length fields at 31 and every other field at 0, except the scope field, which reads 01.
- R2: Writing the control word (word 0) with bit 0 set starts phase 1 on the same clock edge. A length field value f gives a phase of f+1 ticks of TICK_DIV cycles each. Phase 1 therefore expires (len1+1)·TICK_DIV cycles after the enabling edge. That sets status bit 0, and `irq_pre` equals status bit 0 AND control bit 1.
- R3: Phase 2 starts when phase 1 expires and lasts (len2+1)·TICK_DIV cycles. When it expires, `reset_req` is high for exactly one cycle. In that same cycle status bit 1 is set and `irq_tmo` equals status bit 1 AND control bit 2.
- R4: When phase 2 expires, phase 1 restarts at once without a gap, so while the timer stays enabled, reset requests recur every (len1+len2+2)·TICK_DIV cycles.
- R5: A write to the ping word (word 1) during phase 1 clears the tick prescaler and the phase count. A ping on the very edge where phase 1 would expire wins, and no expiry occurs.
- R6: A ping during phase 2 has no effect: the reset request arrives at the time it would have without the ping.
- R7: Writing control bit 0 as 0 returns the block to idle on that edge and clears the counts and the prescaler. No reset request is issued, even when the disable lands on the expiry edge. A later enable starts a fresh phase 1.
- R8: Control bits [5:4] select the reset scope: 00 whole chip, 01 CPU only, 10 software only. `reset_mode` always shows the stored scope. A write of 11 leaves the stored scope unchanged.
- R9: Status bits 0 and 1 are sticky and are cleared by writing 1 to them in word 2. A flag set in the same cycle as a clear stays set. Disabling the timer does not clear them.
- R10: Length fields (len1 at control bits [12:8], len2 at bits [20:16]) written while enabled take effect at the next phase start, never partway through a running phase.
- R11: The control word reads back its fields at the positions above, with unused bits 0. The ping word and word 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word index: 0 control, 1 ping, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word (combinational) |
| irq_pre | output | 1 | Phase 1 expiry interrupt (status bit 0 gated by its enable) |
| irq_tmo | output | 1 | Phase 2 expiry interrupt (status bit 1 gated by its enable) |
| reset_req | output | 1 | One-cycle reset request at phase 2 expiry |
| reset_mode | output | 2 | Reset scope that goes with the request |

## Verification
The main sweep enables the timer for every phase 1 length from 1 to 32, each paired with a different phase 2 length and reset scope. The measured cycle counts to the pre-timeout interrupt and to the reset request separate a wrong tick length, an off-by-one length field, and a phase 2 timed from the wrong origin. Targeted runs then place a ping in the middle of phase 1, on the exact expiry edge and inside phase 2, and a disable on the expiry edge. Mid-phase length rewrites show whether new lengths are picked up at the right phase boundary, and back-to-back reset intervals show whether the restart loses a cycle.

// File: rtl/wdog_pkg.sv
// Package: shared types and register layout for the two-phase watchdog.
// Assumes the phase length fields are LEN_W bits wide and hold length-1.
package wdog_pkg;
    localparam int LEN_W = 5;

    // control word bit positions
    localparam int EN_BIT  = 0;
    localparam int IE1_BIT = 1;
    localparam int IE2_BIT = 2;
    localparam int MODE_LO = 4;
    localparam int LEN1_LO = 8;
    localparam int LEN2_LO = 16;

    // word indices
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PING = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // reset scope codes
    localparam logic [1:0] MODE_SOC  = 2'b00;
    localparam logic [1:0] MODE_CPU  = 2'b01;
    localparam logic [1:0] MODE_SW   = 2'b10;
    localparam logic [1:0] MODE_RSVD = 2'b11;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ONE  = 2'd1,
        PH_TWO  = 2'd2
    } phase_t;

    typedef struct packed {
        logic             en;
        logic             ie1;
        logic             ie2;
        logic [1:0]       mode;
        logic [LEN_W-1:0] len1;
        logic [LEN_W-1:0] len2;
    } wd_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
// Register file: holds the control fields and sticky status flags, decodes
// pings and drives the read mux. Exposes both the current control value and
// the value it takes at the next edge, so the phase logic can act on a write
// in the cycle it happens. Assumes single-cycle writes with no wait states.
module wdog_regs
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    input  logic        set1,
    input  logic        set2,
    output logic [31:0] rdata,
    output wd_cfg_t     cfg_q,
    output wd_cfg_t     cfg_d,
    output logic        ping,
    output logic        sts1,
    output logic        sts2
);
    logic ctrl_wr;
    logic clr1;
    logic clr2;
    logic unused_wbits;

    assign ctrl_wr = we && (addr == ADDR_CTRL);
    assign ping    = we && (addr == ADDR_PING);
    assign clr1    = we && (addr == ADDR_STAT) && wdata[0];
    assign clr2    = we && (addr == ADDR_STAT) && wdata[1];
    assign unused_wbits = ^{wdata[31:21], wdata[15:13], wdata[7:6], wdata[3]};

    // next control value; the reserved scope code is dropped
    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_wr) begin
            cfg_d.en   = wdata[EN_BIT];
            cfg_d.ie1  = wdata[IE1_BIT];
            cfg_d.ie2  = wdata[IE2_BIT];
            cfg_d.len1 = wdata[LEN1_LO +: LEN_W];
            cfg_d.len2 = wdata[LEN2_LO +: LEN_W];
            if (wdata[MODE_LO +: 2] != MODE_RSVD) begin
                cfg_d.mode = wdata[MODE_LO +: 2];
            end
        end
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{en: 1'b0, ie1: 1'b0, ie2: 1'b0, mode: MODE_CPU,
                       len1: {LEN_W{1'b1}}, len2: {LEN_W{1'b1}}};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // sticky status flags, a set beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts1 <= 1'b0;
            sts2 <= 1'b0;
        end else begin
            sts1 <= set1 | (sts1 & ~clr1);
            sts2 <= set2 | (sts2 & ~clr2);
        end
    end

    // read mux
    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL: begin
                rdata[EN_BIT]               = cfg_q.en;
                rdata[IE1_BIT]              = cfg_q.ie1;
                rdata[IE2_BIT]              = cfg_q.ie2;
                rdata[MODE_LO +: 2]         = cfg_q.mode;
                rdata[LEN1_LO +: LEN_W]     = cfg_q.len1;
                rdata[LEN2_LO +: LEN_W]     = cfg_q.len2;
            end
            ADDR_STAT: rdata[1:0] = {sts2, sts1};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_prescale.sv
// Prescaler: divides the bus clock by TICK_DIV into a one-cycle tick strobe.
// A clear holds the count at zero and suppresses the tick. Assumes TICK_DIV >= 1.
module wdog_prescale #(
    parameter int TICK_DIV = 2**28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick = !clr && (pre_q == LAST);

    // divide counter, wraps at LAST
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_phase_ctl.sv
// Phase sequencer: walks idle -> phase 1 -> phase 2 -> phase 1 on ticks,
// latching each phase's length (field value, length-1) when it starts.
// Assumes en_d/len*_d are the control values that hold after this edge.
module wdog_phase_ctl
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_d,
    input  logic [LEN_W-1:0] len1_d,
    input  logic [LEN_W-1:0] len2_d,
    input  logic             ping,
    input  logic             tick,
    output phase_t           phase_q,
    output logic [LEN_W-1:0] cnt_q,
    output logic [LEN_W-1:0] lim_q,
    output logic             pre_clr,
    output logic             exp1,
    output logic             exp2,
    output logic             rst_req
);
    logic at_lim;

    assign at_lim  = (cnt_q == lim_q);
    assign exp1    = en_d && (phase_q == PH_ONE) && !ping && tick && at_lim;
    assign exp2    = en_d && (phase_q == PH_TWO) && tick && at_lim;
    assign pre_clr = !en_d || (phase_q == PH_IDLE) || ((phase_q == PH_ONE) && ping);

    // phase state, tick count and latched limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            lim_q   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= exp2;
            if (!en_d) begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
            end else begin
                unique case (phase_q)
                    PH_IDLE: begin
                        phase_q <= PH_ONE;
                        cnt_q   <= '0;
                        lim_q   <= len1_d;
                    end
                    PH_ONE: begin
                        if (ping) begin
                            cnt_q <= '0;
                            lim_q <= len1_d;
                        end else if (tick) begin
                            if (at_lim) begin
                                phase_q <= PH_TWO;
                                cnt_q   <= '0;
                                lim_q   <= len2_d;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    PH_TWO: begin
                        if (tick) begin
                            if (at_lim) begin
                                phase_q <= PH_ONE;
                                cnt_q   <= '0;
                                lim_q   <= len1_d;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/twophase_wdog.sv
// Top: two-phase watchdog. Connects the register file, prescaler and phase
// sequencer, and gates the sticky flags with their interrupt enables.
// Assumes one bus clock domain and a synchronous active-low reset.
module twophase_wdog
    import wdog_pkg::*;
#(
    parameter int TICK_DIV = 2**28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_pre,
    output logic        irq_tmo,
    output logic        reset_req,
    output logic [1:0]  reset_mode
);
    wd_cfg_t          cfg_q;
    wd_cfg_t          cfg_d;
    logic             ping;
    logic             sts1;
    logic             sts2;
    logic             tick;
    logic             pre_clr;
    logic             exp1;
    logic             exp2;
    phase_t           phase_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] lim_q;

    wdog_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .set1  (exp1),
        .set2  (exp2),
        .rdata (reg_rdata),
        .cfg_q (cfg_q),
        .cfg_d (cfg_d),
        .ping  (ping),
        .sts1  (sts1),
        .sts2  (sts2)
    );

    wdog_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .tick  (tick)
    );

    wdog_phase_ctl u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_d    (cfg_d.en),
        .len1_d  (cfg_d.len1),
        .len2_d  (cfg_d.len2),
        .ping    (ping),
        .tick    (tick),
        .phase_q (phase_q),
        .cnt_q   (cnt_q),
        .lim_q   (lim_q),
        .pre_clr (pre_clr),
        .exp1    (exp1),
        .exp2    (exp2),
        .rst_req (reset_req)
    );

    // interrupt gating and scope output
    always_comb begin
        irq_pre    = sts1 & cfg_q.ie1;
        irq_tmo    = sts2 & cfg_q.ie2;
        reset_mode = cfg_q.mode;
    end
endmodule

// File: rtl/wdog_checker.sv
// Checker: temporal properties of the two-phase watchdog, bound to the top.
module wdog_checker
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_en,
    input phase_t           phase,
    input logic [LEN_W-1:0] cnt,
    input logic [LEN_W-1:0] lim,
    input logic             sts1,
    input logic             sts2,
    input logic             reset_req,
    input logic [1:0]       reset_mode
);
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R3
    AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> sts2); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim); // R2
    AST_ENTRY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TWO && $past(phase) == PH_ONE) |-> sts1); // R2
    AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> !reset_req); // R7
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> phase == PH_IDLE); // R7
    AST_SCOPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        reset_mode != MODE_RSVD); // R8
endmodule

bind twophase_wdog wdog_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_en     (cfg_q.en),
    .phase      (phase_q),
    .cnt        (cnt_q),
    .lim        (lim_q),
    .sts1       (sts1),
    .sts2       (sts2),
    .reset_req  (reset_req),
    .reset_mode (reset_mode)
);

// File: tb/twophase_wdog_test.sv
`timescale 1ns/1ps
module twophase_wdog_test;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq_pre, irq_tmo, reset_req;
    logic [1:0]  reset_mode;

    twophase_wdog #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_pre(irq_pre),
        .irq_tmo(irq_tmo), .reset_req(reset_req), .reset_mode(reset_mode)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // event monitor, samples at the falling edge
    int t1 = -1;
    int nrst = 0;
    int rt[4];
    logic [1:0] rmode = 2'b00;
    logic r_irq2 = 1'b0;
    always @(negedge clk) begin
        if (irq_pre && t1 < 0) t1 = cyc;
        if (reset_req) begin
            if (nrst < 4) rt[nrst] = cyc;
            if (nrst == 0) begin
                rmode  = reset_mode;
                r_irq2 = irq_tmo;
            end
            nrst++;
        end
    end

    function automatic logic [31:0] mk(input bit en, input bit ie1, input bit ie2,
                                       input logic [1:0] md, input int f1, input int f2);
        logic [4:0] a = f1[4:0];
        logic [4:0] b = f2[4:0];
        return {11'b0, b, 3'b0, a, 2'b0, md, 1'b0, ie2, ie1, en};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        we = 1'b0; wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) begin @(negedge clk); #1; end
    endtask

    task automatic arm();
        t1 = -1; nrst = 0;
    endtask

    task automatic quiesce();
        wr(2'd0, mk(0, 0, 0, 2'b01, 0, 0));
        wr(2'd2, 32'd3);
        arm();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int c0, p0, p1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1: reset state
        chk("R1 reset_mode", reset_mode, 1);
        chk("R1 irq_pre", irq_pre, 0);
        chk("R1 irq_tmo", irq_tmo, 0);
        chk("R1 reset_req", reset_req, 0);
        rd(2'd0, v); chk("R1 ctrl", v, mk(0, 0, 0, 2'b01, 31, 31));
        rd(2'd2, v); chk("R1 status", v, 0);

        // R2 R3 R8: sweep every phase 1 length
        for (int l1 = 1; l1 <= 32; l1++) begin
            int l2 = ((l1 * 7) % 32) + 1;
            logic [1:0] md = 2'(l1 % 3);
            quiesce();
            wr(2'd0, mk(1, 1, 1, md, l1 - 1, l2 - 1));
            c0 = cyc;
            wait_until(c0 + (l1 + l2) * DIV + 2);
            chk("R2 phase1 time", t1 - c0, l1 * DIV);
            chk("R3 reset time", rt[0] - c0, (l1 + l2) * DIV);
            chk("R3 single pulse", nrst, 1);
            chk("R3 irq_tmo with req", r_irq2, 1);
            chk("R8 scope at req", rmode, md);
        end

        // R4: back-to-back restart
        quiesce();
        wr(2'd0, mk(1, 1, 1, 2'b01, 2, 1));
        c0 = cyc;
        wait_until(c0 + 10 * DIV + 2);
        chk("R4 first", rt[0] - c0, 5 * DIV);
        chk("R4 interval", rt[1] - rt[0], 5 * DIV);

        // R5: ping mid phase 1, then ping on the expiry edge
        quiesce();
        wr(2'd0, mk(1, 1, 1, 2'b01, 5, 1));
        c0 = cyc;
        wait_until(c0 + 3 * DIV + 1);
        wr(2'd1, 32'd0);
        p0 = cyc;
        chk("R5 no early irq", t1, -1);
        wait_until(p0 + 6 * DIV - 1);
        wr(2'd1, 32'hFFFF_FFFF);
        p1 = cyc;
        chk("R5 ping at expiry", t1, -1);
        wait_until(p1 + 6 * DIV + 1);
        chk("R5 after ping", t1 - p1, 6 * DIV);

        // R6: ping in phase 2 is ignored
        quiesce();
        wr(2'd0, mk(1, 1, 1, 2'b01, 1, 4));
        c0 = cyc;
        wait_until(c0 + 2 * DIV + 1);
        chk("R6 in phase2", irq_pre, 1);
        wr(2'd1, 32'd0);
        wait_until(c0 + 7 * DIV + 2);
        chk("R6 reset time", rt[0] - c0, 7 * DIV);

        // R9: sticky flags, write-one-to-clear, survive disable
        wr(2'd0, mk(0, 1, 1, 2'b01, 1, 4));
        rd(2'd2, v); chk("R9 flags kept", v, 3);
        wr(2'd2, 32'd1);
        rd(2'd2, v); chk("R9 clear bit0", v, 2);
        chk("R9 irq_pre low", irq_pre, 0);
        chk("R9 irq_tmo high", irq_tmo, 1);
        wr(2'd2, 32'd2);
        rd(2'd2, v); chk("R9 clear bit1", v, 0);

        // R2 R3: enables gate the interrupt outputs only
        quiesce();
        wr(2'd0, mk(1, 0, 0, 2'b01, 0, 0));
        c0 = cyc;
        wait_until(c0 + 2 * DIV + 1);
        chk("R2 gated irq_pre", irq_pre, 0);
        chk("R3 gated irq_tmo", irq_tmo, 0);
        rd(2'd2, v); chk("R3 gated status", v, 3);
        chk("R3 gated req", nrst, 1);

        // R7: disable on the expiry edge, then fresh start
        quiesce();
        wr(2'd0, mk(1, 1, 1, 2'b01, 1, 3));
        c0 = cyc;
        wait_until(c0 + 6 * DIV - 1);
        wr(2'd0, mk(0, 1, 1, 2'b01, 1, 3));
        wait_until(c0 + 8 * DIV);
        chk("R7 no req", nrst, 0);
        wr(2'd2, 32'd3);
        arm();
        wr(2'd0, mk(1, 1, 1, 2'b01, 1, 3));
        c0 = cyc;
        wait_until(c0 + 2 * DIV + 1);
        chk("R7 fresh phase1", t1 - c0, 2 * DIV);

        // R10: lengths written mid-phase apply at the next phase start
        quiesce();
        wr(2'd0, mk(1, 1, 1, 2'b01, 3, 1));
        c0 = cyc;
        wait_until(c0 + DIV + 1);
        wr(2'd0, mk(1, 1, 1, 2'b01, 7, 2));
        wait_until(c0 + 18 * DIV + 2);
        chk("R10 old len1", t1 - c0, 4 * DIV);
        chk("R10 new len2", rt[0] - c0, 7 * DIV);
        chk("R10 new len1", rt[1] - rt[0], 11 * DIV);

        // R8 R11: scope codes and readback
        quiesce();
        wr(2'd0, mk(0, 1, 0, 2'b10, 5, 9));
        chk("R8 scope sw", reset_mode, 2);
        rd(2'd0, v); chk("R11 ctrl readback", v, mk(0, 1, 0, 2'b10, 5, 9));
        wr(2'd0, mk(0, 0, 0, 2'b11, 5, 9));
        chk("R8 reserved ignored", reset_mode, 2);
        wr(2'd0, mk(0, 0, 0, 2'b00, 5, 9));
        chk("R8 scope soc", reset_mode, 0);
        rd(2'd1, v); chk("R11 ping reads 0", v, 0);
        rd(2'd3, v); chk("R11 word3 reads 0", v, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule